// File: doc/BRIEF.md
# I2C Target with 7-bit and 10-bit Addressing

This block is the target (slave) end of an I2C link. It sits on the open-drain SCL and SDA lines. It samples them through two-flop synchronizers on the system clock and pulls either line low through a drive-enable output. The device address and the addressing width are static configuration inputs. In 7-bit mode one address byte selects the device. In 10-bit mode a header byte carries the fixed prefix `11110`, the two upper address bits and the direction bit, and a second byte carries the low eight address bits. The general call address can also be answered when it is enabled.

Each byte written by the controller appears on the user side as a data word with a one-cycle valid strobe. The first byte after a general call carries a flag. When the controller reads, the block raises a request for the next byte. It holds SCL low, so the controller waits, until the user side supplies that byte with a one-cycle ready pulse. START and STOP detection works apart from the byte logic. A START at any point restarts address comparison. A STOP drops everything back to idle.

Top module: `i2c_target10`

## Requirements
- R1: In 7-bit mode (`ten_bit_mode`=0), an address byte whose upper seven bits equal `own_addr[6:0]` is acknowledged: SDA is pulled low for the ninth SCL pulse. Bit 0 of that byte selects the direction (0 write, 1 read).
- R2: A non-matching address byte is not acknowledged. SDA is then never pulled low and no byte is delivered until the next START or STOP.
- R3: In 10-bit mode a write header `{5'b11110, own_addr[9:8], 1'b0}` and then a byte equal to `own_addr[7:0]` are both acknowledged, and later bytes are received. A wrong low byte is not acknowledged. A 7-bit address byte is never matched in this mode.
- R4: A read header `{5'b11110, own_addr[9:8], 1'b1}` is acknowledged only after a repeated START that follows a complete matching 10-bit write address. After a STOP the same header is not acknowledged.
- R5: With `gc_enable`=1 the byte 8'h00 is acknowledged and the next received byte is delivered with `rx_gc`=1. Bytes after that carry `rx_gc`=0. With `gc_enable`=0 the byte 8'h00 is not acknowledged.
- R6: Received bytes are sampled on SCL rising edges, most significant bit first. Each byte is acknowledged and delivered on `rx_data` with a single-cycle `rx_valid` pulse.
- R7: For a read, `tx_req` is raised after the falling SCL edge that ends each acknowledge. SCL is held low until a `tx_ready` pulse supplies `tx_data`. The byte is then shifted out MSB first, and `tx_req` stays high until that pulse.
- R8: When the controller does not acknowledge a byte it read, the target releases SDA, stops sending and raises no further `tx_req`.
- R9: A START in the middle of a byte abandons it, and the next byte is compared as an address.
- R10: After reset and after a STOP both drive enables are low and the block is idle.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 10 | Device address; bits 6:0 used in 7-bit mode |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| gc_enable | input | 1 | 1 allows the general call address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_gc | output | 1 | Byte is the first after a general call |
| tx_req | output | 1 | Next read byte needed |
| tx_data | input | 8 | Byte to send |
| tx_ready | input | 1 | One-cycle pulse accepting tx_data |

## Verification
The assertions assume the controller moves SDA only while SCL is low, except to form START and STOP. They also assume every line level lasts several system clocks, so that the synchronizers see each edge, and that the controller never tries a START or STOP while the target holds SDA low. The bench master keeps each bus phase at sixteen system clocks and releases SDA before every ninth pulse and every repeated START. It waits for SCL to actually rise before it counts a high phase. The user-side responder pulses `tx_ready` only while `tx_req` is high.

// File: rtl/i2c_target10.sv
module i2c_target10 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] own_addr,
  input  logic       ten_bit_mode,
  input  logic       gc_enable,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_gc,
  output logic       tx_req,
  input  logic [7:0] tx_data,
  input  logic       tx_ready
);
  localparam logic [4:0] HDR10 = 5'b11110;
  typedef enum logic [2:0] {S_IDLE, S_ADR1, S_ADR2, S_RX, S_TX} st_t;

  st_t        st;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] sr;
  logic       need, hold_q, m10, gc_pend;

  wire scl_s   = scl_sy[1];
  wire sda_s   = sda_sy[1];
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;

  wire hdr_hit = ten_bit_mode && sr[7:3] == HDR10 && sr[2:1] == own_addr[9:8];
  wire a7_hit  = !ten_bit_mode && sr[7:1] == own_addr[6:0];
  wire gc_hit  = gc_enable && sr == 8'h00;

  assign tx_req = need;
  assign scl_oe = need | hold_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1; hold_q <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i}; sda_sy <= {sda_sy[0], sda_i};
      scl_q <= scl_s; sda_q <= sda_s; hold_q <= need;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= 4'd0; sr <= 8'h00; sda_oe <= 1'b0; need <= 1'b0;
      m10 <= 1'b0; gc_pend <= 1'b0; rx_data <= 8'h00; rx_valid <= 1'b0; rx_gc <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (start_c) begin
        st <= S_ADR1; cnt <= 4'd0; sda_oe <= 1'b0; need <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; cnt <= 4'd0; sda_oe <= 1'b0; need <= 1'b0; m10 <= 1'b0; gc_pend <= 1'b0;
      end else if (need) begin
        if (tx_ready) begin
          sr <= tx_data; sda_oe <= ~tx_data[7]; need <= 1'b0;
        end
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (cnt < 4'd8) sr <= {sr[6:0], sda_s};
          cnt <= cnt + 4'd1;
          if (cnt == 4'd8 && st == S_TX && sda_s) st <= S_IDLE;
        end else if (fall) begin
          if (cnt == 4'd8) begin
            case (st)
              S_ADR1: begin
                m10 <= 1'b0; gc_pend <= 1'b0;
                if (hdr_hit && !sr[0]) begin
                  st <= S_ADR2; sda_oe <= 1'b1;
                end else if (hdr_hit && sr[0] && m10) begin
                  st <= S_TX; sda_oe <= 1'b1; m10 <= 1'b1;
                end else if (a7_hit) begin
                  st <= sr[0] ? S_TX : S_RX; sda_oe <= 1'b1;
                end else if (gc_hit) begin
                  st <= S_RX; sda_oe <= 1'b1; gc_pend <= 1'b1;
                end else st <= S_IDLE;
              end
              S_ADR2:
                if (sr == own_addr[7:0]) begin
                  st <= S_RX; sda_oe <= 1'b1; m10 <= 1'b1;
                end else st <= S_IDLE;
              S_RX: begin
                sda_oe <= 1'b1; rx_valid <= 1'b1; rx_data <= sr; rx_gc <= gc_pend; gc_pend <= 1'b0;
              end
              S_TX: sda_oe <= 1'b0;
              default: ;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= 4'd0; sda_oe <= 1'b0;
            if (st == S_TX) need <= 1'b1;
          end else if (st == S_TX) sda_oe <= ~sr[7];
        end
      end
    end

  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st == S_IDLE && !sda_oe && !need));
  a_r9_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == S_ADR1 && !sda_oe && !need));
  a_r7_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> !scl_s);
  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_ready && !start_c && !stop_c) |=> tx_req);
  a_r11_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: tb/i2c_target10_bench.sv
module i2c_target10_bench;
  localparam int Q = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [9:0] own_addr = 10'h03A;
  logic       ten_bit_mode = 1'b0;
  logic       gc_enable = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic       scl_oe, sda_oe, rx_valid, rx_gc, tx_req;
  logic [7:0] rx_data;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready = 1'b0;
  logic       scl_bus, sda_bus;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_target10 u_i2c_target10 (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .ten_bit_mode(ten_bit_mode),
    .gc_enable(gc_enable), .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .rx_data(rx_data), .rx_valid(rx_valid), .rx_gc(rx_gc),
    .tx_req(tx_req), .tx_data(tx_data), .tx_ready(tx_ready));

  int n_cmp = 0, n_bad = 0;
  int stretch_cycles = 0, oe_cycles = 0, sda_high_changes = 0, tx_accepts = 0;
  logic [8:0] rx_exp[$];
  logic [7:0] tx_q[$];
  logic [8:0] e;
  logic       prev_oe = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // scoreboard monitor for received bytes, plus line activity counters
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        if (rx_exp.size() == 0) check(1'b0, "R6", "unexpected rx byte", {rx_gc, rx_data}, 0);
        else begin
          e = rx_exp.pop_front();
          check({rx_gc, rx_data} == e, (e[8] ? "R5" : "R6"), "rx byte", {rx_gc, rx_data}, e);
        end
      end
      if (sda_oe) oe_cycles++;
      if (sda_oe != prev_oe && scl_bus) sda_high_changes++;
      prev_oe = sda_oe;
    end
  end

  // user-side responder: answers each request after a delay
  initial forever begin
    @(negedge clk);
    if (rst_n && tx_req) begin
      repeat (40) @(negedge clk);
      tx_data = (tx_q.size() != 0) ? tx_q.pop_front() : 8'hEE;
      tx_ready = 1'b1;
      tx_accepts++;
      @(negedge clk);
      tx_ready = 1'b0;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_high();
    m_scl = 1'b1;
    @(negedge clk);
    while (!scl_bus) begin stretch_cycles++; @(negedge clk); end
  endtask

  task automatic write_bit(input bit b);
    m_sda = b; hold(Q); clk_high(); hold(Q); m_scl = 1'b0; hold(Q);
  endtask

  task automatic read_bit(output bit b);
    m_sda = 1'b1; hold(Q); clk_high(); hold(Q/2); b = sda_bus; hold(Q/2); m_scl = 1'b0; hold(Q);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; hold(Q); clk_high(); hold(Q); m_sda = 1'b0; hold(Q); m_scl = 1'b0; hold(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; hold(Q); clk_high(); hold(Q); m_sda = 1'b1; hold(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) write_bit(b[i]);
    read_bit(x);
    ack = !x;
  endtask

  task automatic read_byte(output logic [7:0] b, input bit give_ack);
    bit x;
    for (int i = 7; i >= 0; i--) begin read_bit(x); b[i] = x; end
    write_bit(!give_ack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit ack, x;
    logic [7:0] b;
    int acc;
    hold(5);
    check(!sda_oe && !scl_oe, "R10", "drives after reset", {scl_oe, sda_oe}, 0);
    check(!tx_req && !rx_valid, "R10", "user side after reset", {tx_req, rx_valid}, 0);
    rst_n = 1'b1;
    hold(10);

    // R1/R6: 7-bit write
    i2c_start();
    write_byte(8'h74, ack); check(ack, "R1", "7-bit write address ack", ack, 1);
    rx_exp.push_back({1'b0, 8'hA5});
    write_byte(8'hA5, ack); check(ack, "R6", "data ack A5", ack, 1);
    rx_exp.push_back({1'b0, 8'h3C});
    write_byte(8'h3C, ack); check(ack, "R6", "data ack 3C", ack, 1);
    i2c_stop(); hold(8);
    check(!sda_oe && !scl_oe, "R10", "drives after stop", {scl_oe, sda_oe}, 0);

    // R2: mismatch
    i2c_start();
    oe_cycles = 0;
    write_byte(8'h76, ack); check(!ack, "R2", "mismatched address ack", ack, 0);
    write_byte(8'hFF, ack); check(!ack, "R2", "ignored byte FF ack", ack, 0);
    write_byte(8'h00, ack); check(!ack, "R2", "ignored byte 00 ack", ack, 0);
    check(oe_cycles == 0, "R2", "sda pull cycles while ignoring", oe_cycles, 0);
    i2c_stop(); hold(8);

    // R7/R8: 7-bit read with stretching
    tx_q.push_back(8'h96); tx_q.push_back(8'h5A);
    i2c_start();
    write_byte(8'h75, ack); check(ack, "R1", "7-bit read address ack", ack, 1);
    stretch_cycles = 0;
    read_byte(b, 1'b1); check(b == 8'h96, "R7", "first read byte", b, 8'h96);
    check(stretch_cycles > 0, "R7", "scl stretched while waiting", stretch_cycles, 1);
    read_byte(b, 1'b0); check(b == 8'h5A, "R7", "second read byte", b, 8'h5A);
    acc = tx_accepts;
    read_bit(x); check(x == 1'b1, "R8", "sda released after nack", x, 1);
    hold(60);
    check(tx_accepts == acc && !tx_req, "R8", "requests after nack", tx_accepts - acc, 0);
    i2c_stop(); hold(8);

    // R9: start mid-byte
    i2c_start();
    write_bit(1'b0); write_bit(1'b1); write_bit(1'b1); write_bit(1'b1);
    i2c_start();
    write_byte(8'h74, ack); check(ack, "R9", "address after aborting start", ack, 1);
    rx_exp.push_back({1'b0, 8'h11});
    write_byte(8'h11, ack); check(ack, "R9", "data after abort", ack, 1);
    i2c_stop(); hold(8);

    // R5: general call
    gc_enable = 1'b1;
    i2c_start();
    write_byte(8'h00, ack); check(ack, "R5", "general call ack", ack, 1);
    rx_exp.push_back({1'b1, 8'h06});
    write_byte(8'h06, ack);
    rx_exp.push_back({1'b0, 8'h77});
    write_byte(8'h77, ack); check(ack, "R5", "general call data ack", ack, 1);
    i2c_stop(); hold(8);
    gc_enable = 1'b0;
    i2c_start();
    write_byte(8'h00, ack); check(!ack, "R5", "general call disabled ack", ack, 0);
    i2c_stop(); hold(8);

    // R3: 10-bit write
    ten_bit_mode = 1'b1; own_addr = 10'h2C5;
    i2c_start();
    write_byte(8'hF4, ack); check(ack, "R3", "10-bit header ack", ack, 1);
    write_byte(8'hC5, ack); check(ack, "R3", "10-bit low byte ack", ack, 1);
    rx_exp.push_back({1'b0, 8'h42});
    write_byte(8'h42, ack); check(ack, "R3", "10-bit data ack", ack, 1);
    i2c_stop(); hold(8);
    i2c_start();
    write_byte(8'hF4, ack);
    write_byte(8'hC4, ack); check(!ack, "R3", "wrong low byte ack", ack, 0);
    i2c_stop(); hold(8);
    i2c_start();
    write_byte(8'h8A, ack); check(!ack, "R3", "7-bit byte in 10-bit mode ack", ack, 0);
    i2c_stop(); hold(8);

    // R4: 10-bit read via repeated start
    tx_q.push_back(8'hE1);
    i2c_start();
    write_byte(8'hF4, ack);
    write_byte(8'hC5, ack);
    i2c_start();
    write_byte(8'hF5, ack); check(ack, "R4", "read header after repeated start", ack, 1);
    read_byte(b, 1'b0); check(b == 8'hE1, "R4", "10-bit read byte", b, 8'hE1);
    i2c_stop(); hold(8);
    i2c_start();
    write_byte(8'hF5, ack); check(!ack, "R4", "read header after stop", ack, 0);
    i2c_stop(); hold(20);

    check(rx_exp.size() == 0, "R6", "expected bytes left undelivered", rx_exp.size(), 0);
    check(sda_high_changes == 0, "R11", "sda drive changes with scl high", sda_high_changes, 0);
    summary();
    $finish;
  end
endmodule